// File: doc/BRIEF.md
# Media Average and Absolute-Difference Unit

This unit performs the arithmetic that video and media kernels use on pairs of XLEN-bit values. A 3-bit operation code selects one of five functions:
- an unsigned average that rounds up;
- an absolute difference that compares its operands as signed values;
- an absolute difference that compares them as unsigned values;
- either absolute difference added to a destination value the caller supplies.

The sum with the destination value wraps, which suits sum-of-absolute-differences loops.

An operand beat enters through a valid/ready input channel and leaves one cycle later as a registered result on a valid/ready output channel. The output register holds one beat. The input is ready whenever that register is empty or is being drained in the same cycle. When the consumer holds `res_ready` low, the stored result and condition stay frozen and `op_ready` stays low.

A beat may ask for a record form. A record-form beat recomputes a 4-bit condition field from its result. A beat in plain form leaves the condition field as it was.

Top module: `mda_unit`

## Requirements
- R1: `op_ready` is high exactly when `res_valid` is low or `res_ready` is high. A beat accepted on an edge (`op_valid && op_ready`) appears on `res_data`, with `res_valid` high, after that edge. `res_valid` drops after an edge with `res_ready` high and no new beat.
- R2: While `res_valid` is high and `res_ready` is low, `res_data`, `res_cond` and `res_valid` do not change.
- R3: Code 0 (average) gives the upper XLEN bits of the (XLEN+1)-bit sum `a + b + 1`, with both operands zero-extended. Two all-ones operands give all ones.
- R4: Code 1 gives `~a + b + 1` if `a` is signed-less-than `b`, and `~b + a + 1` otherwise, modulo 2^XLEN.
- R5: Code 2 uses the same two formulas as R4 but chooses between them with an unsigned less-than compare.
- R6: Code 3 gives `dst + R4 result` modulo 2^XLEN, with no overflow indication.
- R7: Code 4 gives `dst + R5 result` modulo 2^XLEN.
- R8: Codes 5, 6 and 7 give a zero result.
- R9: A beat accepted with `rec_en` high sets `res_cond` in the same cycle its result appears. Bit 3 means negative, bit 2 means positive and bit 1 means zero, judged from a signed compare of the result against zero. Bit 0 is the `so_in` value of that beat.
- R10: A beat accepted with `rec_en` low leaves `res_cond` unchanged.
- R11: After reset, `res_valid` is 0 and `res_cond` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operand beat present |
| op_ready | output | 1 | Unit can take a beat |
| op_code | input | 3 | Operation select (0..4, others give zero) |
| rec_en | input | 1 | Record form: update condition field |
| so_in | input | 1 | Summary-overflow bit copied into condition bit 0 |
| a_in | input | XLEN | First operand |
| b_in | input | XLEN | Second operand |
| dst_in | input | XLEN | Current destination value for accumulate codes |
| res_valid | output | 1 | Result held |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | XLEN | Result |
| res_cond | output | 4 | Condition field {neg, pos, zero, so} |

## Verification
Random operands drive every operation code with both record and plain forms, so each code is checked against its own reference. Directed beats cover several corners:
- Equal operands must give zero differences and the zero flag.
- The most negative value paired with the most positive one separates the signed compare from the unsigned compare and wraps the difference.
- All-ones operands test whether the average keeps the carry out of the top bit.
- A destination near 2^XLEN shows that the accumulate codes wrap.

Stalls on the output channel confirm that the held result stays stable. They also confirm that a plain-form beat does not disturb a condition field set earlier.

// File: rtl/mda_pkg.sv
package mda_pkg;
  typedef enum logic [2:0] {
    OP_AVG  = 3'd0,
    OP_SABS = 3'd1,
    OP_UABS = 3'd2,
    OP_SACC = 3'd3,
    OP_UACC = 3'd4
  } mda_op_e;

  localparam int CondW = 4;
  localparam int CondNeg  = 3;
  localparam int CondPos  = 2;
  localparam int CondZero = 1;
  localparam int CondSo   = 0;
endpackage

// File: rtl/mda_avg.sv
module mda_avg #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] avg
);
  localparam int SumW = XLEN + 1;
  logic [SumW-1:0] sum;

  // carry-extended rounding add, keep upper XLEN bits
  always_comb begin
    sum = {1'b0, a} + {1'b0, b} + SumW'(1);
    avg = sum[SumW-1:1];
  end
endmodule

// File: rtl/mda_absdiff.sv
module mda_absdiff #(
  parameter int  XLEN   = 32,
  parameter bit  SIGNED = 1'b0
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] diff
);
  logic a_lt_b;

  generate
    if (SIGNED) begin : g_scmp
      assign a_lt_b = $signed(a) < $signed(b);
    end else begin : g_ucmp
      assign a_lt_b = a < b;
    end
  endgenerate

  // complement-plus-one subtraction, operand order chosen by the compare
  always_comb begin
    if (a_lt_b) diff = ~a + b + XLEN'(1);
    else        diff = ~b + a + XLEN'(1);
  end
endmodule

// File: rtl/mda_cond.sv
module mda_cond #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]         value,
  input  logic                    so,
  output logic [mda_pkg::CondW-1:0] cond
);
  import mda_pkg::*;

  always_comb begin
    cond = '0;
    if ($signed(value) < 0)      cond[CondNeg]  = 1'b1;
    else if (value != '0)        cond[CondPos]  = 1'b1;
    else                         cond[CondZero] = 1'b1;
    cond[CondSo] = so;
  end
endmodule

// File: rtl/mda_unit.sv
module mda_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [2:0]      op_code,
  input  logic            rec_en,
  input  logic            so_in,
  input  logic [XLEN-1:0] a_in,
  input  logic [XLEN-1:0] b_in,
  input  logic [XLEN-1:0] dst_in,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [XLEN-1:0] res_data,
  output logic [3:0]      res_cond
);
  import mda_pkg::*;

  localparam int NumCmp = 2; // index 0 signed, index 1 unsigned

  logic [XLEN-1:0] avg_w;
  logic [XLEN-1:0] diff_w [NumCmp];
  logic [XLEN-1:0] nxt_data;
  logic [CondW-1:0] nxt_cond;
  logic in_fire;

  mda_avg #(.XLEN(XLEN)) u_avg (.a(a_in), .b(b_in), .avg(avg_w));

  for (genvar i = 0; i < NumCmp; i++) begin : g_abs
    mda_absdiff #(.XLEN(XLEN), .SIGNED(i == 0)) u_abs (
      .a(a_in), .b(b_in), .diff(diff_w[i])
    );
  end

  always_comb begin
    unique case (op_code)
      OP_AVG:  nxt_data = avg_w;
      OP_SABS: nxt_data = diff_w[0];
      OP_UABS: nxt_data = diff_w[1];
      OP_SACC: nxt_data = dst_in + diff_w[0];
      OP_UACC: nxt_data = dst_in + diff_w[1];
      default: nxt_data = '0;
    endcase
  end

  mda_cond #(.XLEN(XLEN)) u_cond (.value(nxt_data), .so(so_in), .cond(nxt_cond));

  assign op_ready = !res_valid || res_ready;
  assign in_fire  = op_valid && op_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_cond  <= '0;
    end else begin
      if (in_fire) begin
        res_valid <= 1'b1;
        res_data  <= nxt_data;
        if (rec_en) res_cond <= nxt_cond;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_cond)));

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> res_valid);

  assert_bad_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_code > 3'd4) |=> (res_data == '0));

  assert_plain_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !rec_en) |=> $stable(res_cond));

  assert_rec_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && rec_en) |=>
      ($onehot(res_cond[3:1]) && res_cond[0] == $past(so_in)));

  assert_flag_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && rec_en) |=> (res_cond[3] == res_data[XLEN-1]));
endmodule

// File: tb/sim_mda_unit.sv
module sim_mda_unit;
  localparam int W = 32;
  localparam real HALF = 4.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, op_ready;
  logic [2:0] op_code = '0;
  logic rec_en = 1'b0, so_in = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0, dst_in = '0;
  logic res_valid, res_ready = 1'b0;
  logic [W-1:0] res_data;
  logic [3:0] res_cond;

  int total = 0, bad = 0;
  logic [3:0] exp_cond = 4'b0000;

  always #(HALF) clk = ~clk;

  mda_unit #(.XLEN(W)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .rec_en(rec_en), .so_in(so_in), .a_in(a_in), .b_in(b_in),
    .dst_in(dst_in), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_cond(res_cond)
  );

  function automatic logic [W-1:0] ref_avg(logic [W-1:0] a, logic [W-1:0] b);
    return (a >> 1) + (b >> 1) + W'((a[0] | b[0]) ? 1 : 0);
  endfunction

  function automatic logic [W-1:0] ref_abs(logic [W-1:0] a, logic [W-1:0] b, bit sgn);
    longint da, db, d;
    da = sgn ? longint'($signed(a)) : longint'({32'b0, a});
    db = sgn ? longint'($signed(b)) : longint'({32'b0, b});
    d = da - db;
    if (d < 0) d = -d;
    return d[W-1:0];
  endfunction

  function automatic logic [W-1:0] ref_res(logic [2:0] c, logic [W-1:0] a,
                                           logic [W-1:0] b, logic [W-1:0] d);
    case (c)
      3'd0: return ref_avg(a, b);
      3'd1: return ref_abs(a, b, 1'b1);
      3'd2: return ref_abs(a, b, 1'b0);
      3'd3: return d + ref_abs(a, b, 1'b1);
      3'd4: return d + ref_abs(a, b, 1'b0);
      default: return '0;
    endcase
  endfunction

  function automatic logic [3:0] ref_cond(logic [W-1:0] r, logic so);
    if (r[W-1]) return {3'b100, so};
    if (r != 0) return {3'b010, so};
    return {3'b001, so};
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // one beat; stall>0 holds res_ready low for that many cycles
  task automatic beat(logic [2:0] c, logic [W-1:0] a, logic [W-1:0] b,
                      logic [W-1:0] d, logic rec, logic so, int stall, string req);
    logic [W-1:0] er;
    @(negedge clk);
    op_code = c; a_in = a; b_in = b; dst_in = d; rec_en = rec; so_in = so;
    op_valid = 1'b1; res_ready = 1'b0;
    check(op_ready == 1'b1, "R1", W'(op_ready), W'(1));
    er = ref_res(c, a, b, d);
    if (rec) exp_cond = ref_cond(er, so);
    @(negedge clk);
    op_valid = 1'b0;
    check(res_valid == 1'b1, "R1", W'(res_valid), W'(1));
    check(res_data == er, req, res_data, er);
    check(res_cond == exp_cond, rec ? "R9" : "R10", W'(res_cond), W'(exp_cond));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(op_ready == 1'b0, "R1", W'(op_ready), W'(0));
      check(res_valid && res_data == er && res_cond == exp_cond, "R2", res_data, er);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(res_valid == 1'b0, "R1", W'(res_valid), W'(0));
  endtask

  initial begin : watchdog
    #(2.0 * HALF * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [W-1:0] ra, rb, rd;
    logic [2:0] rc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R11", W'(res_valid), W'(0));
    check(res_cond == 4'b0000, "R11", W'(res_cond), W'(0));
    rst_n = 1'b1;
    // directed corners
    beat(3'd0, '1, '1, '0, 1'b1, 1'b0, 0, "R3");
    beat(3'd0, 32'h7, 32'h8, '0, 1'b0, 1'b0, 0, "R3");
    beat(3'd1, 32'h1234, 32'h1234, '0, 1'b1, 1'b1, 2, "R4");
    beat(3'd1, 32'h8000_0000, 32'h7FFF_FFFF, '0, 1'b1, 1'b0, 0, "R4");
    beat(3'd2, 32'h8000_0000, 32'h7FFF_FFFF, '0, 1'b0, 1'b1, 1, "R5");
    beat(3'd2, 32'h5, 32'h9, '0, 1'b1, 1'b0, 0, "R5");
    beat(3'd3, 32'hFFFF_FFF0, 32'h10, 32'h7FFF_FFFF, 1'b1, 1'b0, 0, "R6");
    beat(3'd4, 32'h0, 32'h20, 32'hFFFF_FFF0, 1'b1, 1'b1, 0, "R7");
    beat(3'd4, 32'h3, 32'h3, 32'h0, 1'b1, 1'b0, 0, "R7");
    beat(3'd5, 32'h55, 32'h11, '0, 1'b1, 1'b0, 0, "R8");
    beat(3'd7, 32'h55, 32'h11, '0, 1'b0, 1'b1, 0, "R8");
    // random mix
    for (int i = 0; i < 150; i++) begin
      ra = $urandom; rb = $urandom; rd = $urandom;
      rc = 3'($urandom_range(0, 7));
      case (rc)
        3'd0: beat(rc, ra, rb, rd, 1'($urandom), 1'($urandom), int'($urandom_range(0, 2)), "R3");
        3'd1: beat(rc, ra, rb, rd, 1'($urandom), 1'($urandom), int'($urandom_range(0, 2)), "R4");
        3'd2: beat(rc, ra, rb, rd, 1'($urandom), 1'($urandom), int'($urandom_range(0, 2)), "R5");
        3'd3: beat(rc, ra, rb, rd, 1'($urandom), 1'($urandom), int'($urandom_range(0, 2)), "R6");
        3'd4: beat(rc, ra, rb, rd, 1'($urandom), 1'($urandom), int'($urandom_range(0, 2)), "R7");
        default: beat(rc, ra, rb, rd, 1'($urandom), 1'($urandom), int'($urandom_range(0, 2)), "R8");
      endcase
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule